// File: doc/BRIEF.md
# Four-Entry Page Translation Cache with Tree Pseudo-LRU

This block is a small first-level translation cache for 4KB pages. It sits between a requester and a larger backing translation table. It holds four mappings. Each mapping is keyed by a virtual page number and an address-space identifier. A lookup that hits returns the physical address in the same cycle the request is presented.

On a miss, the block stalls the requester and issues a valid/ready refill request to the backing table. It then waits for the response, which carries a frame number, a coherency attribute and a miss flag.

- If the backing table also misses, the block reports a fault and writes nothing.
- Otherwise the block writes the mapping into a victim entry. The requester, still holding its request, then hits on the following cycle.

The victim is the lowest-numbered invalid entry if one exists. Otherwise it is picked by a three-bit tree: the root bit chooses the less recently used pair, and the pair bit chooses the less recently used entry in that pair.

A flush input clears every entry. The flush is used whenever the backing table changes.

Top module: `utlb4`

## Requirements
- R1: After reset, no lookup hits, and `busy_o`, `fill_req_valid_o` and `fault_o` are all 0.
- R2: When not busy, a request that matches a valid entry raises `hit_o` in the same cycle. In that cycle `pa_o` equals {entry frame, `req_va_i[11:0]`} and `attr_o` carries the entry attribute.
- R3: A request that misses while not busy raises `fill_req_valid_o` in the next cycle, with `fill_req_vpn_o` = `req_va_i[VA_W-1:12]` and `fill_req_asid_o` = `req_asid_i`. The request is held stable until `fill_req_ready_i` is seen.
- R4: A response with `fill_rsp_miss_i` = 0 is written into the cache. In the next cycle the still-held request hits with the returned frame and attribute.
- R5: A response with `fill_rsp_miss_i` = 1 raises `fault_o` in the cycle the response is presented. Nothing is written, so a later access to the same page misses again.
- R6: An entry matches only when both its page number and its address-space identifier equal the request's.
- R7: While any entry is invalid, a refill writes the lowest-numbered invalid entry.
- R8: When all entries are valid, the refill evicts the less recently used entry of the less recently used pair. Use means a hit or a refill, and the state is three tree bits.
- R9: `flush_i` invalidates all entries and resets the tree at the next clock edge. In the following cycle no lookup hits.
- R10: If `flush_i` is seen while a refill is outstanding, the response for that refill is not written.
- R11: `busy_o` is high from the cycle after a miss until the cycle after the response. No hit is reported while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Translation request present |
| req_va_i | input | VA_W | Virtual address |
| req_asid_i | input | ASID_W | Address-space identifier |
| hit_o | output | 1 | Translation returned this cycle |
| pa_o | output | PA_W | Physical address, zero when no hit |
| attr_o | output | ATTR_W | Coherency attribute of the hit entry |
| fault_o | output | 1 | Backing table has no mapping |
| busy_o | output | 1 | Refill in progress, requester stalls |
| fill_req_valid_o | output | 1 | Refill request valid |
| fill_req_ready_i | input | 1 | Refill request accepted |
| fill_req_vpn_o | output | VA_W-12 | Page number to fetch |
| fill_req_asid_o | output | ASID_W | Identifier to fetch |
| fill_rsp_valid_i | input | 1 | Refill response valid |
| fill_rsp_pfn_i | input | PA_W-12 | Returned frame number |
| fill_rsp_attr_i | input | ATTR_W | Returned coherency attribute |
| fill_rsp_miss_i | input | 1 | Backing table missed |

## Verification
The assertions check several rules on every cycle:

- the refill request is held stable until it is accepted;
- a miss always leads to a refill request;
- no hit is reported while busy or on the cycle after a flush;
- a hit's address keeps the request's page offset;
- a fault appears only during a refill.

Only the bench scenarios can show which entry a refill displaced, whether invalid entries are preferred, and whether a flush during a refill drops the write. Each scenario does this by observing later hits and misses.

// File: rtl/utlb4_pkg.sv
package utlb4_pkg;
  localparam int OFF_W = 12;
  localparam int NENT  = 4;
  localparam int IDX_W = $clog2(NENT);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fill_st_e;
endpackage

// File: rtl/utlb4_cam.sv
module utlb4_cam
  import utlb4_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  parameter int ATTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic [ATTR_W-1:0] hit_attr,
  output logic [NENT-1:0]   valid_vec
);
  logic [NENT-1:0]   vld_q, vld_d, match;
  logic [VPN_W-1:0]  vpn_q  [NENT];
  logic [ASID_W-1:0] asid_q [NENT];
  logic [PFN_W-1:0]  pfn_q  [NENT];
  logic [ATTR_W-1:0] attr_q [NENT];

  always_comb begin
    vld_d = vld_q;
    if (flush) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        vpn_q[g]  <= wr_vpn;
        asid_q[g] <= wr_asid;
        pfn_q[g]  <= wr_pfn;
        attr_q[g] <= wr_attr;
      end
    end
    assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
  end

  always_comb begin
    hit_idx  = '0;
    hit_pfn  = '0;
    hit_attr = '0;
    for (int i = 0; i < NENT; i++) begin
      if (match[i]) begin
        hit_idx  = IDX_W'(i);
        hit_pfn  = hit_pfn | pfn_q[i];
        hit_attr = hit_attr | attr_q[i];
      end
    end
  end

  assign hit       = |match;
  assign valid_vec = vld_q;
endmodule

// File: rtl/utlb4_plru.sv
module utlb4_plru
  import utlb4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [NENT-1:0]  valid_vec,
  output logic [IDX_W-1:0] victim
);
  // root: 0 -> pair {0,1} is older; pair bit: 0 -> even entry is older
  logic root_q, root_d, pa_q, pa_d, pb_q, pb_d;
  logic [IDX_W-1:0] tree_pick;

  always_comb begin
    root_d = root_q;
    pa_d   = pa_q;
    pb_d   = pb_q;
    if (flush) begin
      root_d = 1'b0;
      pa_d   = 1'b0;
      pb_d   = 1'b0;
    end else if (upd_en) begin
      root_d = ~upd_idx[1];
      if (upd_idx[1]) pb_d = ~upd_idx[0];
      else            pa_d = ~upd_idx[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= 1'b0;
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
    end else begin
      root_q <= root_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
    end
  end

  assign tree_pick = root_q ? {1'b1, pb_q} : {1'b0, pa_q};

  always_comb begin
    victim = tree_pick;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) victim = IDX_W'(i);
    end
  end
endmodule

// File: rtl/utlb4_ctrl.sv
module utlb4_ctrl
  import utlb4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic req_valid,
  input  logic cam_hit,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic rsp_miss,
  output logic busy,
  output logic fill_valid,
  output logic cap_en,
  output logic wr_en,
  output logic fault
);
  fill_st_e st_q, st_d;
  logic drop_q, drop_d;

  always_comb begin
    st_d       = st_q;
    cap_en     = 1'b0;
    wr_en      = 1'b0;
    fault      = 1'b0;
    fill_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && !cam_hit) begin
          st_d   = ST_REQ;
          cap_en = 1'b1;
        end
      end
      ST_REQ: begin
        fill_valid = 1'b1;
        if (req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          st_d  = ST_IDLE;
          fault = rsp_miss;
          wr_en = !rsp_miss && !drop_q && !flush;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    drop_d = (st_q != ST_IDLE) && (st_d != ST_IDLE) && (drop_q || flush);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      drop_q <= drop_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/utlb4.sv
module utlb4
  import utlb4_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 36,
  parameter int ASID_W = 8,
  parameter int ATTR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_va_i,
  input  logic [ASID_W-1:0]    req_asid_i,
  output logic                 hit_o,
  output logic [PA_W-1:0]      pa_o,
  output logic [ATTR_W-1:0]    attr_o,
  output logic                 fault_o,
  output logic                 busy_o,
  output logic                 fill_req_valid_o,
  input  logic                 fill_req_ready_i,
  output logic [VA_W-13:0]     fill_req_vpn_o,
  output logic [ASID_W-1:0]    fill_req_asid_o,
  input  logic                 fill_rsp_valid_i,
  input  logic [PA_W-13:0]     fill_rsp_pfn_i,
  input  logic [ATTR_W-1:0]    fill_rsp_attr_i,
  input  logic                 fill_rsp_miss_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              cam_hit, cap_en, wr_en, upd_en;
  logic [IDX_W-1:0]  hit_idx, victim, upd_idx;
  logic [PFN_W-1:0]  hit_pfn;
  logic [ATTR_W-1:0] hit_attr;
  logic [NENT-1:0]   valid_vec;
  logic [VPN_W-1:0]  cap_vpn_q;
  logic [ASID_W-1:0] cap_asid_q;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  always_ff @(posedge clk) begin
    if (cap_en) begin
      cap_vpn_q  <= req_va_i[VA_W-1:OFF_W];
      cap_asid_q <= req_asid_i;
    end
  end

  utlb4_cam #(
    .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .flush    (flush_i),
    .wr_en    (wr_en),
    .wr_idx   (victim),
    .wr_vpn   (cap_vpn_q),
    .wr_asid  (cap_asid_q),
    .wr_pfn   (fill_rsp_pfn_i),
    .wr_attr  (fill_rsp_attr_i),
    .lk_vpn   (req_va_i[VA_W-1:OFF_W]),
    .lk_asid  (req_asid_i),
    .hit      (cam_hit),
    .hit_idx  (hit_idx),
    .hit_pfn  (hit_pfn),
    .hit_attr (hit_attr),
    .valid_vec(valid_vec)
  );

  utlb4_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .flush     (flush_i),
    .req_valid (req_valid_i),
    .cam_hit   (cam_hit),
    .req_ready (fill_req_ready_i),
    .rsp_valid (fill_rsp_valid_i),
    .rsp_miss  (fill_rsp_miss_i),
    .busy      (busy_o),
    .fill_valid(fill_req_valid_o),
    .cap_en    (cap_en),
    .wr_en     (wr_en),
    .fault     (fault_o)
  );

  assign hit_o   = req_valid_i && !busy_o && cam_hit;
  assign upd_en  = hit_o || wr_en;
  assign upd_idx = wr_en ? victim : hit_idx;

  utlb4_plru u_plru (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .flush    (flush_i),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .valid_vec(valid_vec),
    .victim   (victim)
  );

  assign pa_o            = hit_o ? {hit_pfn, req_va_i[OFF_W-1:0]} : '0;
  assign attr_o          = hit_o ? hit_attr : '0;
  assign fill_req_vpn_o  = cap_vpn_q;
  assign fill_req_asid_o = cap_asid_q;
endmodule

// File: rtl/utlb4_chk.sv
module utlb4_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 36,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              req_valid_i,
  input logic [VA_W-1:0]   req_va_i,
  input logic              hit_o,
  input logic [PA_W-1:0]   pa_o,
  input logic              fault_o,
  input logic              busy_o,
  input logic              fill_req_valid_o,
  input logic              fill_req_ready_i,
  input logic [VA_W-13:0]  fill_req_vpn_o,
  input logic [ASID_W-1:0] fill_req_asid_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid_o && !fill_req_ready_i) |=>
      (fill_req_valid_o && $stable(fill_req_vpn_o) && $stable(fill_req_asid_o))); // R3
  AST_MISS_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !busy_o && !hit_o) |=> fill_req_valid_o); // R3
  AST_NO_HIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !hit_o); // R11
  AST_FAULT_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> busy_o); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit_o); // R9
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (pa_o[11:0] == req_va_i[11:0])); // R2
endmodule

bind utlb4 utlb4_chk #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush_i         (flush_i),
  .req_valid_i     (req_valid_i),
  .req_va_i        (req_va_i),
  .hit_o           (hit_o),
  .pa_o            (pa_o),
  .fault_o         (fault_o),
  .busy_o          (busy_o),
  .fill_req_valid_o(fill_req_valid_o),
  .fill_req_ready_i(fill_req_ready_i),
  .fill_req_vpn_o  (fill_req_vpn_o),
  .fill_req_asid_o (fill_req_asid_o)
);

// File: tb/utlb4_tb.sv
module utlb4_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, flush;
  logic        req_valid;
  logic [31:0] req_va;
  logic [7:0]  req_asid;
  logic        hit;
  logic [35:0] pa;
  logic [2:0]  attr;
  logic        fault, busy;
  logic        fq_valid, fq_ready;
  logic [19:0] fq_vpn;
  logic [7:0]  fq_asid;
  logic        fr_valid, fr_miss;
  logic [23:0] fr_pfn;
  logic [2:0]  fr_attr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  utlb4 u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_asid_i(req_asid),
    .hit_o(hit), .pa_o(pa), .attr_o(attr), .fault_o(fault), .busy_o(busy),
    .fill_req_valid_o(fq_valid), .fill_req_ready_i(fq_ready),
    .fill_req_vpn_o(fq_vpn), .fill_req_asid_o(fq_asid),
    .fill_rsp_valid_i(fr_valid), .fill_rsp_pfn_i(fr_pfn),
    .fill_rsp_attr_i(fr_attr), .fill_rsp_miss_i(fr_miss)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] mpfn(logic [19:0] v, logic [7:0] a);
    return {a[3:0], v} ^ 24'h5A5A5;
  endfunction
  function automatic logic [2:0] mattr(logic [19:0] v, logic [7:0] a);
    return v[2:0] ^ a[2:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // one translation; acts as the backing table on a miss
  task automatic access(input logic [31:0] va, input logic [7:0] asid,
                        input bit exp_hit, input bit jmiss, input int lat,
                        input bit flush_mid, input string rq);
    logic [23:0] ep = mpfn(va[31:12], asid);
    logic [2:0]  ea = mattr(va[31:12], asid);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = asid;
    #1;
    chk(hit == exp_hit, rq, "hit on presentation", 64'(hit), 64'(exp_hit));
    if (hit) begin
      chk(pa == {ep, va[11:0]}, "R2", "pa on hit", 64'(pa), 64'({ep, va[11:0]}));
      chk(attr == ea, "R2", "attr on hit", 64'(attr), 64'(ea));
      return;
    end
    @(negedge clk); #1;
    chk(fq_valid && fq_vpn == va[31:12] && fq_asid == asid, "R3", "fill request",
        64'({fq_valid, fq_vpn, fq_asid}), 64'({1'b1, va[31:12], asid}));
    chk(busy && !hit, "R11", "busy during refill", 64'({busy, hit}), 64'(2'b10));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk); #1;
      chk(fq_valid && fq_vpn == va[31:12], "R3", "request held",
          64'({fq_valid, fq_vpn}), 64'({1'b1, va[31:12]}));
    end
    fq_ready = 1'b1;
    flush = flush_mid;
    @(negedge clk);
    fq_ready = 1'b0; flush = 1'b0;
    fr_valid = 1'b1; fr_pfn = ep; fr_attr = ea; fr_miss = jmiss;
    #1;
    chk(fault == jmiss, "R5", "fault with response", 64'(fault), 64'(jmiss));
    chk(!hit, "R11", "no hit while waiting", 64'(hit), 64'(0));
    @(negedge clk);
    fr_valid = 1'b0; fr_miss = 1'b0;
    if (jmiss || flush_mid) begin
      req_valid = 1'b0;
      #1;
      chk(!busy && !fault, "R11", "idle after response", 64'({busy, fault}), 64'(0));
    end else begin
      #1;
      chk(hit && pa == {ep, va[11:0]}, "R4", "hit after refill",
          64'({hit, pa}), 64'({1'b1, ep, va[11:0]}));
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(!hit && !busy && !fq_valid && !fault, "R1", "reset outputs",
        64'({hit, busy, fq_valid, fault}), 64'(0));
    access(32'h0001_2345, 8'h01, 1'b0, 1'b0, 0, 1'b0, "R1");
  endtask

  task automatic t_hit();
    access(32'h0001_2345, 8'h01, 1'b1, 1'b0, 0, 1'b0, "R2");
    access(32'h0001_2FFC, 8'h01, 1'b1, 1'b0, 0, 1'b0, "R2");
  endtask

  task automatic t_asid();
    access(32'h0001_2345, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R6");
    access(32'h0001_2000, 8'h01, 1'b1, 1'b0, 0, 1'b0, "R6");
    access(32'h0001_3345, 8'h01, 1'b0, 1'b0, 0, 1'b0, "R6");
  endtask

  task automatic t_jmiss();
    access(32'h00F0_0010, 8'h03, 1'b0, 1'b1, 0, 1'b0, "R5");
    access(32'h00F0_0010, 8'h03, 1'b0, 1'b1, 0, 1'b0, "R5");
  endtask

  task automatic t_latency();
    access(32'h0ABC_D004, 8'h05, 1'b0, 1'b0, 3, 1'b0, "R3");
  endtask

  task automatic t_flush();
    do_flush();
    #1;
    chk(!busy, "R9", "idle after flush", 64'(busy), 64'(0));
    access(32'h0001_2345, 8'h01, 1'b0, 1'b0, 0, 1'b0, "R9");
  endtask

  task automatic t_flush_mid();
    access(32'h0777_7000, 8'h07, 1'b0, 1'b0, 1, 1'b1, "R10");
    access(32'h0777_7000, 8'h07, 1'b0, 1'b0, 0, 1'b0, "R10");
  endtask

  task automatic t_invalid_first();
    do_flush();
    access(32'h0000_A000, 8'h01, 1'b0, 1'b0, 0, 1'b0, "R7");
    access(32'h0000_B000, 8'h01, 1'b0, 1'b0, 0, 1'b0, "R7");
    access(32'h0000_A000, 8'h01, 1'b1, 1'b0, 0, 1'b0, "R7");
    access(32'h0000_C000, 8'h01, 1'b0, 1'b0, 0, 1'b0, "R7");
    access(32'h0000_B000, 8'h01, 1'b1, 1'b0, 0, 1'b0, "R7");
  endtask

  task automatic t_plru();
    do_flush();
    access(32'h0010_A000, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_B000, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_C000, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_D000, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_A000, 8'h02, 1'b1, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_E000, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_A000, 8'h02, 1'b1, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_B000, 8'h02, 1'b1, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_D000, 8'h02, 1'b1, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_E000, 8'h02, 1'b1, 1'b0, 0, 1'b0, "R8");
    access(32'h0010_C000, 8'h02, 1'b0, 1'b0, 0, 1'b0, "R8");
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_va = '0; req_asid = '0;
    fq_ready = 1'b0; fr_valid = 1'b0; fr_miss = 1'b0; fr_pfn = '0; fr_attr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_hit();
    t_asid();
    t_jmiss();
    t_latency();
    t_flush();
    t_flush_mid();
    t_invalid_first();
    t_plru();
    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule